// File: doc/BRIEF.md
# Signed Bounds Check Flag and Trap Unit

This unit decides whether a signed integer lies inside an allowed range and reports the result as condition-flag updates plus a trap request. It has two modes. The single-bound mode checks the value against the range from zero up to an upper bound. The dual-bound mode checks the value against an explicit lower bound and an explicit upper bound. For every flag it can touch, the unit also gives a write enable, so an execution pipeline knows which condition flags to update and which to leave unchanged.

One check is accepted in each cycle on which `in_valid` is high. The result shows up on the registered outputs on the next clock edge, together with a one-cycle `out_valid` pulse. Where a simpler rule would leave a flag undefined, the unit gives it a fixed value, and that includes the case where the bounds of a range are given in inverted order. A two-state machine sequences the outputs. In ST_IDLE every output is zero. ST_RESULT presents one captured result. The transition ST_IDLE to ST_RESULT, and ST_RESULT to ST_RESULT, is taken when `in_valid` is high. The transitions ST_RESULT to ST_IDLE and ST_IDLE to ST_IDLE are taken when it is low.

Top module: `bounds_check_unit`

## Requirements
- R1: The outputs that belong to a check accepted with `in_valid` high on clock edge k appear after edge k and remain until edge k+1. `out_valid` is high for exactly the cycles that follow an accepted check.
- R2: In a cycle where `out_valid` is low, `trap_req`, all three flags and all three write enables are 0.
- R3: Single-bound mode is selected with `mode_dual`=0. In this mode `flag_n` is 1 when the value is negative and 0 otherwise. `we_n`=1, `we_c`=1, `we_z`=0 and `flag_z`=0. The `lower` input has no effect in this mode.
- R4: In single-bound mode with upper ≥ 0, `flag_c` is 1 exactly when value < 0 or value > upper.
- R5: In single-bound mode with upper < 0, `flag_c` is 1 exactly when value > upper and also value < 0.
- R6: In single-bound mode, `trap_req` is 1 exactly when value < 0 or value > upper. This holds even when `flag_c` is 0 because the upper bound is negative.
- R7: Dual-bound mode is selected with `mode_dual`=1. In this mode `flag_z` is 1 exactly when the value equals the lower bound or the upper bound. `we_z`=1, `we_c`=1, `we_n`=0 and `flag_n`=0.
- R8: In dual-bound mode with lower ≤ upper, `flag_c` is 1 exactly when value < lower or value > upper.
- R9: In dual-bound mode with lower > upper, `flag_c` is 1 exactly when value > upper and also value < lower.
- R10: In dual-bound mode, `trap_req` equals `flag_c`.
- R11: Every comparison treats its operands as two's-complement signed WIDTH-bit numbers. Under this rule the most negative number is below zero and below every bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A check is presented this cycle |
| mode_dual | input | 1 | 0 = single-bound (0..upper), 1 = dual-bound (lower..upper) |
| value | input | WIDTH | Signed value under test |
| lower | input | WIDTH | Signed lower bound (dual-bound mode only) |
| upper | input | WIDTH | Signed upper bound |
| out_valid | output | 1 | Result present this cycle |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| we_n | output | 1 | Negative flag is to be written |
| we_z | output | 1 | Zero flag is to be written |
| we_c | output | 1 | Carry flag is to be written |
| trap_req | output | 1 | Value out of range, trap requested |

## Verification
Each operand is drawn from an eight-entry set: the two signed extremes, -2, -1, 0, 1, 2 and 5. The bench sweeps every combination of operands in both modes. In single-bound mode the negative upper bounds separate the carry rule from the trap rule (R5 against R6), and a varied `lower` shows that this input is ignored. In dual-bound mode every ordered pair of bounds occurs, so the sweep covers normal ranges, inverted ranges and equal bounds, and it hits each bound exactly, which exercises the zero flag. The most negative value sits at the edge of signed comparison. An idle cycle after every check confirms that the outputs return to zero.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic {
        BC_SINGLE = 1'b0,
        BC_DUAL   = 1'b1
    } bc_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bc_state_e;

    typedef struct packed {
        logic trap;
        logic n;
        logic z;
        logic c;
        logic wen;
        logic wez;
        logic wec;
    } bc_result_t;
endpackage

// File: rtl/bc_range_cmp.sv
module bc_range_cmp #(
    parameter int WIDTH = 32
) (
    input  logic signed [WIDTH-1:0] val,
    input  logic signed [WIDTH-1:0] lo,
    input  logic signed [WIDTH-1:0] hi,
    output logic                    below_lo,
    output logic                    above_hi,
    output logic                    at_lo,
    output logic                    at_hi,
    output logic                    inverted
);
    always_comb begin
        below_lo = val < lo;
        above_hi = val > hi;
        at_lo    = val == lo;
        at_hi    = val == hi;
        inverted = lo > hi;
    end
endmodule

// File: rtl/bc_flag_eval.sv
module bc_flag_eval
    import bc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  bc_mode_e                mode,
    input  logic signed [WIDTH-1:0] val,
    input  logic signed [WIDTH-1:0] lo,
    input  logic signed [WIDTH-1:0] hi,
    output bc_result_t              res
);
    localparam logic signed [WIDTH-1:0] ZERO = '0;

    logic signed [WIDTH-1:0] eff_lo;
    logic below_lo, above_hi, at_lo, at_hi, inverted;
    logic is_neg, carry;

    // single-bound mode is the dual rule with the lower bound pinned at zero
    assign eff_lo = (mode == BC_SINGLE) ? ZERO : lo;
    assign is_neg = val[WIDTH-1];

    bc_range_cmp #(.WIDTH(WIDTH)) cmp_i (
        .val      (val),
        .lo       (eff_lo),
        .hi       (hi),
        .below_lo (below_lo),
        .above_hi (above_hi),
        .at_lo    (at_lo),
        .at_hi    (at_hi),
        .inverted (inverted)
    );

    always_comb begin
        carry = inverted ? (above_hi & below_lo) : (above_hi | below_lo);
        res   = '0;
        unique case (mode)
            BC_SINGLE: begin
                res.n    = is_neg;
                res.c    = carry;
                res.wen  = 1'b1;
                res.wec  = 1'b1;
                res.trap = is_neg | above_hi;
            end
            BC_DUAL: begin
                res.z    = at_lo | at_hi;
                res.c    = carry;
                res.wez  = 1'b1;
                res.wec  = 1'b1;
                res.trap = carry;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bounds_check_unit.sv
module bounds_check_unit
    import bc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_dual,
    input  logic [WIDTH-1:0] value,
    input  logic [WIDTH-1:0] lower,
    input  logic [WIDTH-1:0] upper,
    output logic             out_valid,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             we_n,
    output logic             we_z,
    output logic             we_c,
    output logic             trap_req
);
    bc_state_e  state_q, state_d;
    bc_result_t eval_res, res_q, res_out;

    bc_flag_eval #(.WIDTH(WIDTH)) eval_i (
        .mode (bc_mode_e'(mode_dual)),
        .val  ($signed(value)),
        .lo   ($signed(lower)),
        .hi   ($signed(upper)),
        .res  (eval_res)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= in_valid ? eval_res : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESULT: res_out = res_q;
            ST_IDLE:   res_out = '0;
            default:   res_out = '0;
        endcase
        out_valid = (state_q == ST_RESULT);
        flag_n    = res_out.n;
        flag_z    = res_out.z;
        flag_c    = res_out.c;
        we_n      = res_out.wen;
        we_z      = res_out.wez;
        we_c      = res_out.wec;
        trap_req  = res_out.trap;
    end
endmodule

// File: rtl/bounds_check_unit_chk.sv
module bounds_check_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_dual,
    input logic [WIDTH-1:0] value,
    input logic [WIDTH-1:0] upper,
    input logic             out_valid,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             we_n,
    input logic             we_z,
    input logic             we_c,
    input logic             trap_req
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !trap_req && !we_n && !we_z && !we_c && !flag_n && !flag_z && !flag_c);
    a_r3_single_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_dual) |=> (we_n && we_c && !we_z && !flag_z));
    a_r6_negative_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_dual && value[WIDTH-1]) |=> (trap_req && flag_n));
    a_r7_dual_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_dual) |=> (we_z && we_c && !we_n && !flag_n));
    a_r10_dual_trap_is_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_dual) |=> (trap_req == flag_c));
    a_r5_neg_bound_value_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_dual && upper[WIDTH-1] && !value[WIDTH-1]) |=> (!flag_c && trap_req));
endmodule

bind bounds_check_unit bounds_check_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_dual (mode_dual),
    .value     (value),
    .upper     (upper),
    .out_valid (out_valid),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .we_n      (we_n),
    .we_z      (we_z),
    .we_c      (we_c),
    .trap_req  (trap_req)
);

// File: tb/bounds_check_unit_tb.sv
module bounds_check_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 32;
    localparam int NSET       = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             mode_dual = 1'b0;
    logic [WIDTH-1:0] value = '0;
    logic [WIDTH-1:0] lower = '0;
    logic [WIDTH-1:0] upper = '0;
    logic out_valid, flag_n, flag_z, flag_c, we_n, we_z, we_c, trap_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bounds_check_unit #(.WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_dual(mode_dual),
        .value(value), .lower(lower), .upper(upper),
        .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .we_n(we_n), .we_z(we_z), .we_c(we_c), .trap_req(trap_req)
    );

    function automatic longint pick(input int i);
        case (i)
            0: return -64'sd2147483648;
            1: return -64'sd2;
            2: return -64'sd1;
            3: return 64'sd0;
            4: return 64'sd1;
            5: return 64'sd2;
            6: return 64'sd5;
            default: return 64'sd2147483647;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b (mode=%0b v=%0d lo=%0d hi=%0d)",
                     req, act, exp, mode_dual, $signed(value), $signed(lower), $signed(upper));
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, out_valid, 1'b0);
        chk(req, trap_req | flag_n | flag_z | flag_c | we_n | we_z | we_c, 1'b0);
    endtask

    task automatic run_one(input logic md, input longint v, input longint lo, input longint hi);
        logic en, ez, ec, et;
        en = 0; ez = 0; ec = 0; et = 0;
        @(negedge clk);
        mode_dual = md;
        value = v[WIDTH-1:0];
        lower = lo[WIDTH-1:0];
        upper = hi[WIDTH-1:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", out_valid, 1'b1);
        if (!md) begin
            en = (v < 0);
            ec = (hi >= 0) ? (v < 0 || v > hi) : (v > hi && v < 0);
            et = (v < 0 || v > hi);
            chk("R3", flag_n, en);
            chk("R3", {we_n, we_z, we_c, flag_z} == 4'b1010, 1'b1);
            chk(hi >= 0 ? "R4" : "R5", flag_c, ec);
            chk("R6", trap_req, et);
        end else begin
            ez = (v == lo || v == hi);
            ec = (lo <= hi) ? (v < lo || v > hi) : (v > hi && v < lo);
            chk("R7", flag_z, ez);
            chk("R7", {we_n, we_z, we_c, flag_n} == 4'b0110, 1'b1);
            chk(lo <= hi ? "R8" : "R9", flag_c, ec);
            chk("R10", trap_req, ec);
        end
        if (v == -64'sd2147483648)
            chk("R11", md ? (trap_req == (lo <= hi ? lo != v : 1'b0)) : trap_req, 1'b1);
        @(negedge clk);
        check_idle("R2");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check_idle("R2");
                rst_n = 1'b1;
                @(negedge clk);
                check_idle("R2");
                for (int i = 0; i < NSET; i++)
                    for (int j = 0; j < NSET; j++)
                        run_one(1'b0, pick(i), pick((i + j) % NSET), pick(j));
                for (int i = 0; i < NSET; i++)
                    for (int j = 0; j < NSET; j++)
                        for (int k = 0; k < NSET; k++)
                            run_one(1'b1, pick(i), pick(j), pick(k));
                done = 1'b1;
            end
            begin
                repeat (50000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule